// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel of a memory-mapped event timer. It watches a free-running main tick counter supplied from outside and emits a one-cycle interrupt pulse when the counter reaches or passes a programmable comparator. Each channel can run in one-shot or periodic mode. It can compare over the full counter width or over only the lower half, called narrow mode here: 32 bits when the counter is 64 bits wide.

Software programs the channel through a configuration strobe and two write strobes that load the lower or upper half of the comparator. In periodic mode those writes normally land in a stored period. After each match the channel advances the comparator by that period. A set-value bit in the configuration lets software load the comparator itself while the channel is periodic. A narrow one-shot channel also fires when the lower half of the counter rolls over from all ones to zero.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the interrupt output is low, and both capability outputs (periodic-capable, full-width-capable) read 1.
- R2: In one-shot mode the channel pulses `irq_o` high for exactly one cycle, in the cycle after the first edge at which the counter equals or has passed the comparator since the previous edge, for any counter step size. The comparator does not change on its own.
- R3: A pulse on `irq_o` occurs only if the channel enable bit and `glb_en_i` were both 1 in the cycle that caused it.
- R4: In periodic mode with a non-zero period and `glb_en_i` high, every edge at which the comparator is not ahead of the counter adds the period to the comparator, one addition per cycle, until it is ahead again. Each crossing gives one pulse.
- R5: In periodic mode a comparator half write goes to the period and leaves the comparator readback unchanged, unless the set-value bit is 1. With set-value, a lower-half write loads the comparator and the period. Any comparator half write clears set-value.
- R6: A written period is clamped to half the range: in narrow mode bit 31 of a lower-half write is cleared, and in full-width mode bit 31 of an upper-half write (counter bit 63) is cleared.
- R7: A configuration write that selects narrow mode clears the upper 32 bits of both the comparator and the period. Upper-half writes are ignored while narrow.
- R8: In narrow mode "ahead" and "reached" use the sign of the 32-bit difference of the lower halves, so matches stay correct across a lower-half rollover and the counter's upper bits are ignored. In narrow periodic mode the addition is modulo 2^32.
- R9: A narrow one-shot channel also pulses once when the lower 32 bits of the counter roll over. A periodic channel does not.
- R10: A comparator or configuration write takes effect at the next clock edge and is visible on `cmp_o` right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Current main counter value |
| glb_en_i | input | 1 | Global enable: counter running, interrupts allowed |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Configuration: channel interrupt enable |
| cfg_periodic_i | input | 1 | Configuration: periodic mode |
| cfg_narrow_i | input | 1 | Configuration: 32-bit compare width |
| cfg_setval_i | input | 1 | Configuration: next comparator write loads the comparator directly |
| cmp_lo_we_i | input | 1 | Write strobe, lower 32 bits of comparator/period |
| cmp_hi_we_i | input | 1 | Write strobe, upper 32 bits of comparator/period |
| wdata_i | input | 32 | Write data for a half write |
| irq_o | output | 1 | One-cycle interrupt pulse |
| cmp_o | output | 64 | Comparator readback |
| cap_periodic_o | output | 1 | Capability: periodic mode available |
| cap_wide_o | output | 1 | Capability: 64-bit compare available |

## Verification
The hardest states to reach are the narrow-mode corners: a one-shot channel whose lower counter half rolls over before the match, and a periodic channel that must catch up several periods after the counter jumps. The bench puts the counter next to 0xFFFFFFFA with the channel disabled, then enables it and steps across the rollover. This shows the rollover pulse and the later match pulse in distinct cycles. For catch-up it jumps the counter forward by several periods in one step and holds it, then computes the final comparator arithmetically. A sweep over step sizes and comparator offsets checks the one-shot pulse cycle against a ceiling division.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

    typedef struct packed {
        logic en;
        logic periodic;
        logic narrow;
        logic setval;
    } chan_cfg_t;

endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic                   glb_en_i,
    input  logic                   cfg_we_i,
    input  chan_cfg_t              cfg_wr_i,
    input  logic                   lo_we_i,
    input  logic                   hi_we_i,
    input  logic [CNT_W/2-1:0]     wdata_i,
    output chan_cfg_t              cfg_o,
    output logic [CNT_W-1:0]       cmp_o
);
    localparam int HALF = CNT_W / 2;
    localparam logic [HALF-1:0] CLAMP = {1'b0, {(HALF-1){1'b1}}};

    typedef struct packed {
        chan_cfg_t        cfg;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
    } regs_t;

    regs_t q, d;
    logic [CNT_W-1:0] diff;
    logic [CNT_W-1:0] sum;
    logic             ahead;

    always_comb begin
        d    = q;
        diff = q.cmp - cnt_i;
        if (q.cfg.narrow)
            ahead = (diff[HALF-1:0] != '0) && !diff[HALF-1];
        else
            ahead = (diff != '0) && !diff[CNT_W-1];

        sum = q.cmp + q.per;
        if (q.cfg.narrow)
            sum[CNT_W-1:HALF] = '0;

        // periodic reload: one addition per cycle until ahead again
        if (glb_en_i && q.cfg.periodic && (q.per != '0) && !ahead)
            d.cmp = sum;

        if (lo_we_i) begin
            if (!q.cfg.periodic || q.cfg.setval)
                d.cmp[HALF-1:0] = wdata_i;
            if (q.cfg.periodic)
                d.per[HALF-1:0] = q.cfg.narrow ? (wdata_i & CLAMP) : wdata_i;
            d.cfg.setval = 1'b0;
        end

        if (hi_we_i) begin
            if (!q.cfg.narrow) begin
                if (!q.cfg.periodic || q.cfg.setval)
                    d.cmp[CNT_W-1:HALF] = wdata_i;
                else
                    d.per[CNT_W-1:HALF] = wdata_i & CLAMP;
            end
            d.cfg.setval = 1'b0;
        end

        if (cfg_we_i) begin
            d.cfg = cfg_wr_i;
            if (cfg_wr_i.narrow) begin
                d.cmp[CNT_W-1:HALF] = '0;
                d.per[CNT_W-1:HALF] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg <= '0;
            q.cmp <= '1;
            q.per <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg_o = q.cfg;
    assign cmp_o = q.cmp;

endmodule

// File: rtl/evt_cmp_match.sv
module evt_cmp_match #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             narrow_i,
    input  logic             periodic_i,
    output logic             hit_o,
    output logic             wrap_o
);
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic             vld;
    } match_t;

    match_t q, d;

    function automatic logic reached(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] x,
                                     input logic             nar);
        logic [CNT_W-1:0] df;
        df = c - x;
        if (nar)
            return (df[HALF-1:0] == '0) || df[HALF-1];
        return (df == '0) || df[CNT_W-1];
    endfunction

    always_comb begin
        d.prev = cnt_i;
        d.vld  = 1'b1;
        hit_o  = q.vld && reached(cmp_i, cnt_i, narrow_i)
                       && !reached(cmp_i, q.prev, narrow_i);
        wrap_o = q.vld && narrow_i && !periodic_i
                       && (q.prev[HALF-1:0] > cnt_i[HALF-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               glb_en_i,
    input  logic               cfg_we_i,
    input  logic               cfg_en_i,
    input  logic               cfg_periodic_i,
    input  logic               cfg_narrow_i,
    input  logic               cfg_setval_i,
    input  logic               cmp_lo_we_i,
    input  logic               cmp_hi_we_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic               irq_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic               cap_periodic_o,
    output logic               cap_wide_o
);
    chan_cfg_t cfg_wr;
    chan_cfg_t cfg_q;
    logic      hit, wrap;
    logic      chan_en_w, periodic_w, narrow_w;
    logic      irq_d, irq_q;

    assign cfg_wr = '{en: cfg_en_i, periodic: cfg_periodic_i,
                      narrow: cfg_narrow_i, setval: cfg_setval_i};

    evt_cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt_i),
        .glb_en_i (glb_en_i),
        .cfg_we_i (cfg_we_i),
        .cfg_wr_i (cfg_wr),
        .lo_we_i  (cmp_lo_we_i),
        .hi_we_i  (cmp_hi_we_i),
        .wdata_i  (wdata_i),
        .cfg_o    (cfg_q),
        .cmp_o    (cmp_o)
    );

    assign chan_en_w  = cfg_q.en;
    assign periodic_w = cfg_q.periodic;
    assign narrow_w   = cfg_q.narrow;

    evt_cmp_match #(.CNT_W(CNT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_i),
        .cmp_i      (cmp_o),
        .narrow_i   (narrow_w),
        .periodic_i (periodic_w),
        .hit_o      (hit),
        .wrap_o     (wrap)
    );

    always_comb begin
        irq_d = (hit || wrap) && chan_en_w && glb_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o          = irq_q;
    assign cap_periodic_o = 1'b1;
    assign cap_wide_o     = 1'b1;

endmodule

module evt_cmp_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             chan_en,
    input logic             periodic,
    input logic             narrow,
    input logic             cfg_we,
    input logic             lo_we,
    input logic             hi_we,
    input logic             irq,
    input logic [CNT_W-1:0] cmp
);
    localparam int HALF = CNT_W / 2;

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(glb_en && chan_en));

    assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (cmp[CNT_W-1:HALF] == '0));

    assert_oneshot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !cfg_we && !lo_we && !hi_we) |=> $stable(cmp));

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cfg_we && !lo_we && !hi_we) |=> $stable(cmp));

endmodule

bind evt_cmp_channel evt_cmp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en_i),
    .chan_en  (chan_en_w),
    .periodic (periodic_w),
    .narrow   (narrow_w),
    .cfg_we   (cfg_we_i),
    .lo_we    (cmp_lo_we_i),
    .hi_we    (cmp_hi_we_i),
    .irq      (irq_o),
    .cmp      (cmp_o)
);

// File: tb/tb_evt_cmp_channel.sv
module tb_evt_cmp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_i = '0;
    logic        glb_en_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_en_i = 1'b0;
    logic        cfg_periodic_i = 1'b0;
    logic        cfg_narrow_i = 1'b0;
    logic        cfg_setval_i = 1'b0;
    logic        cmp_lo_we_i = 1'b0;
    logic        cmp_hi_we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        irq_o;
    logic [63:0] cmp_o;
    logic        cap_periodic_o, cap_wide_o;

    int          checks = 0;
    int          fails = 0;
    int          npulse;
    longint      pulse_t;
    logic [63:0] first_at, last_at;

    always #2 clk = ~clk;

    evt_cmp_channel dut (.*);

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_pulses();
        npulse = 0; pulse_t = 0; first_at = '0; last_at = '0;
    endtask

    // drive counter, let one edge pass, sample at the following negedge
    task automatic tick(input logic [63:0] c, input longint t);
        cnt_i = c;
        @(negedge clk);
        if (irq_o) begin
            if (npulse == 0) begin first_at = c; pulse_t = t; end
            last_at = c;
            npulse++;
        end
    endtask

    task automatic wr_cfg(input logic en, input logic per, input logic nar, input logic sv);
        cfg_en_i = en; cfg_periodic_i = per; cfg_narrow_i = nar; cfg_setval_i = sv;
        cfg_we_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] v);
        wdata_i = v; cmp_lo_we_i = 1'b1;
        @(negedge clk);
        cmp_lo_we_i = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] v);
        wdata_i = v; cmp_hi_we_i = 1'b1;
        @(negedge clk);
        cmp_hi_we_i = 1'b0;
    endtask

    initial begin
        logic [63:0] c0;
        longint      expn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cmp after reset", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 irq after reset", {63'd0, irq_o}, 64'd0);
        chk("R1 periodic capability", {63'd0, cap_periodic_o}, 64'd1);
        chk("R1 wide capability", {63'd0, cap_wide_o}, 64'd1);

        // R3 gating: channel disabled, then global disabled
        glb_en_i = 1'b1;
        tick(64'd90, 0);
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        wr_hi(32'd0);
        wr_lo(32'd100);
        chk("R10 cmp visible after write", cmp_o, 64'd100);
        clr_pulses();
        for (int i = 91; i <= 105; i++) tick(64'(i), i);
        chk("R3 no pulse with channel disabled", 64'(npulse), 64'd0);
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        glb_en_i = 1'b0;
        tick(64'd90, 0);
        clr_pulses();
        for (int i = 91; i <= 105; i++) tick(64'(i), i);
        chk("R3 no pulse with global disabled", 64'(npulse), 64'd0);
        glb_en_i = 1'b1;

        // R2 one-shot sweep over step sizes and comparator offsets
        for (int s = 1; s <= 6; s++) begin
            for (int k = 1; k <= 10; k++) begin
                tick(64'd1000, 0);
                wr_lo(32'(1000 + k));
                clr_pulses();
                for (int t = 1; t <= 12; t++) tick(64'(1000 + s * t), t);
                chk($sformatf("R2 pulse count step=%0d off=%0d", s, k), 64'(npulse), 64'd1);
                chk($sformatf("R2 pulse cycle step=%0d off=%0d", s, k),
                    64'(pulse_t), 64'((k + s - 1) / s));
                chk("R2 one-shot cmp unchanged", cmp_o, 64'(1000 + k));
            end
        end

        // R4 periodic reload with several periods
        for (int p = 3; p <= 7; p += 2) begin
            wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
            tick(64'd1990, 0);
            wr_cfg(1'b1, 1'b1, 1'b0, 1'b1);
            wr_hi(32'd0);
            wr_cfg(1'b1, 1'b1, 1'b0, 1'b1);
            wr_lo(32'd2000);
            wr_lo(32'(p));
            clr_pulses();
            for (int i = 1991; i <= 2029; i++) tick(64'(i), i);
            expn = 29 / p + 1;
            chk($sformatf("R4 periodic pulses p=%0d", p), 64'(npulse), 64'(expn));
            chk($sformatf("R4 periodic cmp p=%0d", p), cmp_o, 64'(2000 + p * expn));
            // catch-up after a jump of five periods
            c0 = cmp_o;
            clr_pulses();
            for (int h = 0; h < 9; h++) tick(c0 + 64'(5 * p + 1), h);
            chk("R4 one pulse on jump", 64'(npulse), 64'd1);
            chk("R4 catch-up cmp", cmp_o, c0 + 64'(6 * p));
        end

        // R6 narrow period clamp (bit 31 of lower half)
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        tick(64'h0F0, 0);
        wr_cfg(1'b1, 1'b1, 1'b1, 1'b1);
        wr_lo(32'h100);
        wr_lo(32'h8000_0010);
        clr_pulses();
        for (int i = 'hF1; i <= 'h130; i++) tick(64'(i), i);
        chk("R6 narrow clamp pulses", 64'(npulse), 64'd4);
        chk("R6 narrow clamp cmp", cmp_o, 64'h140);

        // R6 wide period clamp (bit 63 via upper-half write)
        wr_cfg(1'b1, 1'b1, 1'b0, 1'b1);
        wr_lo(32'h200);
        wr_hi(32'h8000_0000);
        wr_lo(32'd5);
        clr_pulses();
        for (int i = 'h131; i <= 'h200; i++) tick(64'(i), i);
        chk("R6 wide clamp pulses", 64'(npulse), 64'd1);
        chk("R6 wide clamp cmp", cmp_o, 64'h205);

        // R7 narrow switch clears upper comparator half
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        wr_hi(32'd5);
        wr_lo(32'h123);
        chk("R10 wide cmp loaded", cmp_o, 64'h5_0000_0123);
        wr_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 upper cmp cleared", cmp_o, 64'h123);
        wr_hi(32'd7);
        chk("R7 upper write ignored in narrow", cmp_o, 64'h123);

        // R7 narrow switch clears upper period half
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        wr_lo(32'h300);
        wr_hi(32'd1);
        wr_lo(32'd4);
        wr_cfg(1'b0, 1'b1, 1'b1, 1'b0);
        wr_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        clr_pulses();
        for (int i = 'h201; i <= 'h300; i++) tick(64'(i), i);
        chk("R7 upper period cleared", cmp_o, 64'h304);

        // R5 set-value behaviour
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        wr_lo(32'h777);
        chk("R5 periodic write leaves cmp", cmp_o, 64'h304);
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        wr_lo(32'h900);
        chk("R5 set-value write loads cmp", cmp_o, 64'h900);
        wr_lo(32'hABC);
        chk("R5 set-value cleared after write", cmp_o, 64'h900);

        // R8 / R9 narrow one-shot across lower-half rollover
        wr_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        tick(64'h0000_0000_FFFF_FFFA, 0);
        wr_lo(32'd5);
        wr_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        clr_pulses();
        for (int i = 0; i < 14; i++) tick(64'h0000_0000_FFFF_FFFB + 64'(i), i);
        chk("R9 narrow one-shot pulse count", 64'(npulse), 64'd2);
        chk("R9 rollover pulse position", first_at, 64'h1_0000_0000);
        chk("R8 narrow match ignores upper bits", last_at, 64'h1_0000_0005);

        // R9 no rollover pulse in periodic narrow
        wr_cfg(1'b0, 1'b1, 1'b1, 1'b1);
        tick(64'h1_FFFF_FFF0, 0);
        wr_lo(32'h1000);
        wr_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        clr_pulses();
        for (int i = 1; i <= 20; i++) tick(64'h1_FFFF_FFF0 + 64'(i), i);
        chk("R9 periodic narrow no rollover pulse", 64'(npulse), 64'd0);
        chk("R8 narrow cmp ahead across rollover", cmp_o, 64'h1000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule